// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the outcomes of the most recent branches and a table of 2-bit saturating counters. Each cycle, the fetch stage presents a PC. The block XORs PC bits [HIST_W+1:2] with the history to form a table index. It returns the counter's most significant bit as the predicted direction, all in the same cycle. Because the index mixes in global history, the behaviour of other branches shapes each prediction.

The fetch stage keeps the index and the history snapshot that come out with each prediction. When the branch resolves, it hands them back on the update port together with the real outcome. The block then trains the counter at that exact index, even if the history has moved on since the prediction. It also shifts the outcome into the history. If the branch was mispredicted, the caller asserts the restore flag. The history is then rebuilt from the snapshot plus the real outcome, which drops any younger, wrong-path outcomes.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds weakly not-taken (01), so every PC predicts not-taken and `pred_hist` reads 0.
- R2: `pred_idx` equals `pred_pc[HIST_W+1:2]` XOR the current history, combinationally.
- R3: `pred_taken` is bit 1 (the MSB) of the counter at `pred_idx`, in the same cycle as `pred_pc`.
- R4: An update with `upd_taken`=1 raises the addressed counter by one, and a counter at 11 stays at 11.
- R5: An update with `upd_taken`=0 lowers the addressed counter by one, and a counter at 00 stays at 00.
- R6: Training writes the entry named by `upd_idx`, whatever the history holds at update time.
- R7: On an update without restore, the history shifts left by one and takes `upd_taken` into bit 0. Without an update, the history holds.
- R8: On an update with `upd_restore`=1, the history becomes `{upd_hist[HIST_W-2:0], upd_taken}`.
- R9: When a prediction and an update hit the same entry in one cycle, the prediction shows the counter value from before that update.
- R10: Two PCs that produce the same index share one counter: training through one changes the prediction for the other.
- R11: `pred_hist` presents the current history, to be used as the snapshot for a later restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_idx | output | HIST_W | Table index used for this prediction |
| pred_hist | output | HIST_W | History snapshot at prediction time |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_idx | input | HIST_W | Index returned from prediction time |
| upd_taken | input | 1 | Actual outcome |
| upd_restore | input | 1 | Mispredict: rebuild history from `upd_hist` |
| upd_hist | input | HIST_W | History snapshot returned from prediction time |

## Verification
The assertions take for granted that `upd_valid`, `upd_taken` and `upd_restore` are never unknown after reset. They also assume `upd_restore` only means something while `upd_valid` is high. The bench drives every update input from a defined value in every cycle. It asserts restore only together with a valid update. The index and snapshot it returns are ones the block produced earlier, taken from a queue of pending predictions. This keeps the bench inside the contract a fetch pipeline would honour.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'b00;
   localparam ctr_t CTR_WEAK_NT   = 2'b01;
   localparam ctr_t CTR_STRONG_T  = 2'b11;

   // saturating step of a 2-bit direction counter
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/gshare_hist_reg.sv
module gshare_hist_reg #(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic              upd_taken,
   input  logic              restore_en,
   input  logic [HIST_W-1:0] restore_val,
   output logic [HIST_W-1:0] hist_o
);

   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_base;
   logic              unused_restore_msb;

   generate
      if (HIST_W < 2) begin : g_bad_width
         $error("gshare_hist_reg: HIST_W must be at least 2");
      end
   endgenerate

   assign unused_restore_msb = restore_val[HIST_W-1];
   assign hist_base = restore_en ? restore_val : hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      hist_q <= '0;
      else if (upd_en) hist_q <= {hist_base[HIST_W-2:0], upd_taken};
   end

   assign hist_o = hist_q;

   // R7
   hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && !restore_en |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken)});
   // R7
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(hist_q));
   // R8
   hist_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && restore_en |=> hist_q == {$past(restore_val[HIST_W-2:0]), $past(upd_taken)});

endmodule

// File: rtl/gshare_index_hash.sv
module gshare_index_hash #(
   parameter int HIST_W = 12,
   parameter int PC_W   = 32
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [HIST_W-1:0] idx
);

   localparam int PC_LSB = 2;

   logic unused_pc_bits;

   generate
      if (PC_W < HIST_W + PC_LSB + 1) begin : g_bad_pc
         $error("gshare_index_hash: PC_W too narrow for HIST_W");
      end
      for (genvar b = 0; b < HIST_W; b++) begin : g_bit
         assign idx[b] = pc[b + PC_LSB] ^ hist[b];
      end
   endgenerate

   assign unused_pc_bits = ^{pc[PC_W-1:HIST_W+PC_LSB], pc[PC_LSB-1:0]};

endmodule

// File: rtl/gshare_counter_table.sv
module gshare_counter_table
   import gshare_pkg::*;
#(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   localparam int ENTRIES = 1 << IDX_W;

   ctr_t ctr_q [ENTRIES];

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("gshare_counter_table: IDX_W out of range 1..16");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= CTR_WEAK_NT;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
      end
   end

   // read sees the pre-write contents in a same-cycle collision
   assign rd_ctr = ctr_q[rd_idx];

   // R4
   ctr_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_taken && ctr_q[wr_idx] == CTR_STRONG_T |=> ctr_q[$past(wr_idx)] == CTR_STRONG_T);
   // R4
   ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_taken && ctr_q[wr_idx] != CTR_STRONG_T
      |=> ctr_q[$past(wr_idx)] == ctr_t'($past(ctr_q[wr_idx]) + 2'd1));
   // R5
   ctr_bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_taken && ctr_q[wr_idx] == CTR_STRONG_NT |=> ctr_q[$past(wr_idx)] == CTR_STRONG_NT);
   // R5
   ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_taken && ctr_q[wr_idx] != CTR_STRONG_NT
      |=> ctr_q[$past(wr_idx)] == ctr_t'($past(ctr_q[wr_idx]) - 2'd1));

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
   import gshare_pkg::*;
#(
   parameter int HIST_W = 12,
   parameter int PC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   pred_pc,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_idx,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [HIST_W-1:0] upd_idx,
   input  logic              upd_taken,
   input  logic              upd_restore,
   input  logic [HIST_W-1:0] upd_hist
);

   logic [HIST_W-1:0] hist;
   logic [HIST_W-1:0] idx;
   ctr_t              rd_ctr;

   gshare_hist_reg #(.HIST_W(HIST_W)) i_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_en      (upd_valid),
      .upd_taken   (upd_taken),
      .restore_en  (upd_restore),
      .restore_val (upd_hist),
      .hist_o      (hist)
   );

   gshare_index_hash #(.HIST_W(HIST_W), .PC_W(PC_W)) i_hash (
      .pc   (pred_pc),
      .hist (hist),
      .idx  (idx)
   );

   gshare_counter_table #(.IDX_W(HIST_W)) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (idx),
      .rd_ctr   (rd_ctr),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken)
   );

   assign pred_taken = rd_ctr[1];
   assign pred_idx   = idx;
   assign pred_hist  = hist;

   // R1
   reset_hist_chk: assert property (@(posedge clk)
      !rst_n |=> pred_hist == '0);

endmodule

// File: tb/test_gshare_predictor.sv
module test_gshare_predictor;

   localparam int HW      = 12;
   localparam int PW      = 32;
   localparam int ENTRIES = 1 << HW;
   localparam int MASK    = ENTRIES - 1;
   localparam time CLK_P  = 20ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] pred_pc = '0;
   logic          pred_taken;
   logic [HW-1:0] pred_idx;
   logic [HW-1:0] pred_hist;
   logic          upd_valid = 1'b0;
   logic [HW-1:0] upd_idx = '0;
   logic          upd_taken = 1'b0;
   logic          upd_restore = 1'b0;
   logic [HW-1:0] upd_hist = '0;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural reference state
   int m_ctr [ENTRIES];
   int m_hist;

   always #(CLK_P/2) clk = ~clk;

   gshare_predictor #(.HIST_W(HW), .PC_W(PW)) i_gshare_predictor (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_idx(pred_idx), .pred_hist(pred_hist), .upd_valid(upd_valid),
      .upd_idx(upd_idx), .upd_taken(upd_taken), .upd_restore(upd_restore),
      .upd_hist(upd_hist)
   );

   function automatic int m_index(input logic [PW-1:0] pc);
      return ((int'(pc) >>> 2) ^ m_hist) & MASK;
   endfunction

   function automatic logic [PW-1:0] pc_for_index(input int want, input int upper);
      return PW'((upper << (HW + 2)) | (((want ^ m_hist) & MASK) << 2));
   endfunction

   task automatic compare(input string tag, input int act, input int exp, input string what);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // one clock: drive at falling edge, compare, then advance the model at the rising edge
   task automatic step(input logic [PW-1:0] pc, input logic uv, input int uidx,
                       input logic ut, input logic ur, input int uh, input string tag);
      int ei;
      @(negedge clk);
      pred_pc     = pc;
      upd_valid   = uv;
      upd_idx     = HW'(uidx);
      upd_taken   = ut;
      upd_restore = ur;
      upd_hist    = HW'(uh);
      #1;
      ei = m_index(pc);
      compare(tag, int'(pred_idx), ei, "index");
      compare(tag, int'(pred_taken), (m_ctr[ei] >> 1) & 1, "taken");
      compare(tag, int'(pred_hist), m_hist, "history");
      @(posedge clk);
      if (uv) begin
         if (ut && m_ctr[uidx] < 3) m_ctr[uidx]++;
         else if (!ut && m_ctr[uidx] > 0) m_ctr[uidx]--;
         m_hist = (((ur ? uh : m_hist) << 1) | int'(ut)) & MASK;
      end
   endtask

   task automatic idle(input logic [PW-1:0] pc, input string tag);
      step(pc, 1'b0, 0, 1'b0, 1'b0, 0, tag);
   endtask

   task automatic train(input logic [PW-1:0] pc, input logic ut, input string tag);
      step(pc, 1'b1, m_index(pc), ut, 1'b0, 0, tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int old_idx;
      int q_idx[$];
      int q_hist[$];
      int q_out[$];
      logic [PW-1:0] pa;
      for (int e = 0; e < ENTRIES; e++) m_ctr[e] = 1;
      m_hist = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: fresh state everywhere
      for (int k = 0; k < 64; k++) idle(PW'($urandom), "R1");

      // R2 R3 R7: a loop branch, three taken then one not-taken
      pa = 32'h0000_4a3c;
      for (int k = 0; k < 24; k++) train(pa, (k % 4) != 3, "R2_R3_R7");

      // R4 R5: saturation at both ends on one fixed index
      for (int k = 0; k < 6; k++) step(32'h100, 1'b1, 77, 1'b1, 1'b0, 0, "R4");
      step(pc_for_index(77, 3), 1'b0, 0, 1'b0, 1'b0, 0, "R4");
      for (int k = 0; k < 7; k++) step(32'h104, 1'b1, 77, 1'b0, 1'b0, 0, "R5");
      idle(pc_for_index(77, 5), "R5");

      // R6: train with a stale index after the history has moved
      old_idx = m_index(32'h0000_0880);
      idle(32'h0000_0880, "R6");
      train(32'h0000_1234, 1'b1, "R6");
      train(32'h0000_5678, 1'b0, "R6");
      train(32'h0000_9abc, 1'b1, "R6");
      step(32'h0, 1'b1, old_idx, 1'b1, 1'b0, 0, "R6");
      idle(pc_for_index(old_idx, 1), "R6");

      // R8: restore from a snapshot
      step(32'h40, 1'b1, 5, 1'b1, 1'b1, 12'hA5C, "R8");
      idle(32'h40, "R8");
      step(32'h44, 1'b1, 6, 1'b0, 1'b1, 12'hFFF, "R8");
      idle(32'h44, "R8");

      // R9: predict and train the same entry in one cycle
      for (int k = 0; k < 3; k++) begin
         pa = pc_for_index(300, k);
         step(pa, 1'b1, 300, 1'b1, 1'b0, 0, "R9");
      end
      idle(pc_for_index(300, 9), "R9");

      // R10: aliasing PCs share a counter
      idle(pc_for_index(900, 2), "R10");
      step(pc_for_index(900, 1), 1'b1, 900, 1'b1, 1'b0, 0, "R10");
      idle(pc_for_index(900, 7), "R10");

      // R11 and mixed traffic: delayed updates from a queue, occasional restore
      for (int k = 0; k < 3000; k++) begin
         logic [PW-1:0] pc;
         logic uv, ut, ur;
         int ui, uh;
         pc = PW'($urandom);
         uv = 1'b0; ut = 1'b0; ur = 1'b0; ui = 0; uh = 0;
         if (q_idx.size() > 3) begin
            uv = 1'b1;
            ui = q_idx.pop_front();
            uh = q_hist.pop_front();
            ut = q_out.pop_front() != 0;
            ur = ($urandom % 8) == 0;
         end
         q_idx.push_back(m_index(pc));
         q_hist.push_back(m_hist);
         q_out.push_back(int'($urandom % 3 != 0));
         step(pc, uv, ui, ut, ur, uh, "R11");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule